// File: doc/BRIEF.md
# Hashed Direct-Mapped Instruction Translation Table

This block turns the effective address of an instruction fetch into a real address. It uses a small table with one entry per slot. Each entry holds a valid bit, an effective-address tag and a full 64-bit page table entry. The slot for an address is chosen by folding three adjacent page-number fields together with XOR, so pages that differ only in their upper index fields still spread across the table. The fetch side presents an address, a translation-enable flag and a privilege flag. Within the same cycle the block returns the real address and a grant signal. When translation is off, the address passes straight through.

The memory-management side updates the table through a separate port. A load writes the tag and the page table entry into the hashed slot. An invalidate clears the hashed slot without comparing the tag, or clears the whole table when the invalidate address carries a nonzero "all" field. A sticky fail flag records any requested fetch that was refused, so that later pipeline stages can turn it into an instruction fault. That flag stays set until a flush, a table load or a reset.

Top module: `itlb_xlate`

## Requirements
- R1: Reset clears every valid bit and the fail flag. After reset, every translated lookup is refused until an entry is loaded.
- R2: The slot index for any address (fetch or update) is ea[17:12] XOR ea[23:18] XOR ea[29:24] with the default 64 entries and 4 KiB pages. Two addresses with equal folded index share one slot.
- R3: A translated lookup hits only when the selected slot is valid and its stored tag equals ea[63:18]. On a hit, real_addr is page table entry bits [55:12] joined to ea[11:0].
- R4: With xlate_en low, real_addr equals ea[55:0] and access_ok is 1, whatever the table holds and whatever priv_en is.
- R5: Page table entry bit 3 marks a supervisor-only page. A translated hit on such a page with priv_en low gives access_ok 0. With priv_en high the access is granted.
- R6: A load (mmu_load high, mmu_inval low) writes tag mmu_ea[63:18] and mmu_pte into slot index(mmu_ea) and sets it valid. Lookups see the new entry from the next cycle.
- R7: A single invalidate (mmu_inval high, mmu_ea[11:10] zero) clears the valid bit of slot index(mmu_ea), even when the stored tag differs from mmu_ea[63:18].
- R8: An invalidate with mmu_ea[11:10] nonzero clears the valid bits of all slots.
- R9: When mmu_inval and mmu_load are high in the same cycle, the invalidate is performed and the load is dropped.
- R10: fetch_fail goes to 1 on the edge after a cycle with fetch_req high and access_ok low. It then holds. It returns to 0 on the edge after a cycle with flush or mmu_load high, and clearing wins over setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | A fetch is being requested this cycle |
| fetch_ea | input | 64 | Fetch effective address |
| xlate_en | input | 1 | Translate through the table when 1; pass through when 0 |
| priv_en | input | 1 | Fetch runs in privileged mode when 1 |
| flush | input | 1 | Clears the fail flag |
| mmu_load | input | 1 | Write an entry at the hashed slot of mmu_ea |
| mmu_inval | input | 1 | Invalidate one slot or, by mmu_ea[11:10], all slots |
| mmu_ea | input | 64 | Effective address for update or invalidate |
| mmu_pte | input | 64 | Page table entry to store on a load |
| real_addr | output | 56 | Translated or passed-through real address |
| access_ok | output | 1 | Translation valid and no privilege fault |
| fetch_fail | output | 1 | Sticky record of a refused requested fetch |

## Verification
The block has three timings. real_addr and access_ok follow the fetch inputs in the same cycle. A table update is seen by lookups from the cycle after its clock edge. fetch_fail changes one edge after the cycle that causes the change. The bench drives every input just after a falling edge. One nanosecond later it compares the combinational outputs with a reference model, using the model's table as it stood before the coming rising edge. Only after that edge does it apply the cycle's updates to the model, so the fail flag and all table changes are expected exactly one cycle after their cause.

// File: rtl/itlb_pkg.sv
`timescale 1ns/1ps
package itlb_pkg;

  // update action chosen for the current cycle; kill actions outrank a load
  typedef enum logic [1:0] {
    UPD_NONE     = 2'd0,
    UPD_LOAD     = 2'd1,
    UPD_KILL_ONE = 2'd2,
    UPD_KILL_ALL = 2'd3
  } upd_op_e;

  // page table entry bit that restricts a page to privileged fetches
  localparam int PTE_PRIV_BIT = 3;

  // number of index-width fields folded into the slot index
  localparam int HASH_FOLDS = 3;

endpackage

// File: rtl/itlb_hash.sv
`timescale 1ns/1ps
module itlb_hash #(
  parameter int EA_BITS   = 64,
  parameter int PAGE_BITS = 12,
  parameter int IDX_BITS  = 6
) (
  input  logic [EA_BITS-1:0]  ea,
  output logic [IDX_BITS-1:0] idx
);
  import itlb_pkg::*;

  localparam int HASH_TOP = PAGE_BITS + HASH_FOLDS * IDX_BITS;

  logic [IDX_BITS-1:0] field [HASH_FOLDS];

  // slice consecutive page-number fields above the page offset
  for (genvar g = 0; g < HASH_FOLDS; g++) begin : g_field
    assign field[g] = ea[PAGE_BITS + g*IDX_BITS +: IDX_BITS];
  end

  always_comb begin
    idx = '0;
    for (int g = 0; g < HASH_FOLDS; g++) begin
      idx = idx ^ field[g];
    end
  end

  logic unused_ea_bits;
  assign unused_ea_bits = ^{ea[EA_BITS-1:HASH_TOP], ea[PAGE_BITS-1:0]};

endmodule

// File: rtl/itlb_entries.sv
`timescale 1ns/1ps
module itlb_entries #(
  parameter int ENTRIES  = 64,
  parameter int IDX_BITS = 6,
  parameter int TAG_BITS = 46,
  parameter int PTE_BITS = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  itlb_pkg::upd_op_e    op,
  input  logic [IDX_BITS-1:0]  widx,
  input  logic [TAG_BITS-1:0]  wtag,
  input  logic [PTE_BITS-1:0]  wpte,
  input  logic [IDX_BITS-1:0]  ridx,
  output logic                 rvalid,
  output logic [TAG_BITS-1:0]  rtag,
  output logic [PTE_BITS-1:0]  rpte
);
  import itlb_pkg::*;

  // tag and entry payload: write-only synchronous port, asynchronous read,
  // no reset so they map onto distributed RAM
  logic [TAG_BITS-1:0] tag_mem [ENTRIES];
  logic [PTE_BITS-1:0] pte_mem [ENTRIES];

  // valid bits in flops so the whole table can be cleared in one cycle
  logic [ENTRIES-1:0]  vld;

  always_ff @(posedge clk) begin
    if (op == UPD_LOAD) begin
      tag_mem[widx] <= wtag;
      pte_mem[widx] <= wpte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || op == UPD_KILL_ALL) begin
      vld <= '0;
    end else if (op == UPD_KILL_ONE) begin
      vld[widx] <= 1'b0;
    end else if (op == UPD_LOAD) begin
      vld[widx] <= 1'b1;
    end
  end

  assign rvalid = vld[ridx];
  assign rtag   = tag_mem[ridx];
  assign rpte   = pte_mem[ridx];

endmodule

// File: rtl/itlb_prot.sv
`timescale 1ns/1ps
module itlb_prot #(
  parameter int EA_BITS   = 64,
  parameter int RA_BITS   = 56,
  parameter int PAGE_BITS = 12,
  parameter int PTE_BITS  = 64
) (
  input  logic                xlate_en,
  input  logic                priv_en,
  input  logic                hit,
  input  logic [EA_BITS-1:0]  ea,
  input  logic [PTE_BITS-1:0] pte,
  output logic [RA_BITS-1:0]  ra,
  output logic                ok
);
  import itlb_pkg::*;

  logic page_priv;
  logic xl_valid;

  always_comb begin
    if (xlate_en) begin
      ra        = {pte[RA_BITS-1:PAGE_BITS], ea[PAGE_BITS-1:0]};
      xl_valid  = hit;
      page_priv = pte[PTE_PRIV_BIT];
    end else begin
      ra        = ea[RA_BITS-1:0];
      xl_valid  = 1'b1;
      page_priv = 1'b0;
    end
    ok = xl_valid && !(page_priv && !priv_en);
  end

  logic unused_prot_bits;
  assign unused_prot_bits = ^{ea[EA_BITS-1:RA_BITS], pte[PTE_BITS-1:RA_BITS],
                              pte[PAGE_BITS-1:0]};

endmodule

// File: rtl/itlb_xlate.sv
`timescale 1ns/1ps
module itlb_xlate #(
  parameter int ENTRIES      = 64,
  parameter int PAGE_BITS    = 12,
  parameter int RA_BITS      = 56,
  parameter int EA_BITS      = 64,
  parameter int PTE_BITS     = 64,
  parameter int KILL_ALL_LSB = 10,
  parameter int KILL_ALL_MSB = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fetch_req,
  input  logic [EA_BITS-1:0]  fetch_ea,
  input  logic                xlate_en,
  input  logic                priv_en,
  input  logic                flush,
  input  logic                mmu_load,
  input  logic                mmu_inval,
  input  logic [EA_BITS-1:0]  mmu_ea,
  input  logic [PTE_BITS-1:0] mmu_pte,
  output logic [RA_BITS-1:0]  real_addr,
  output logic                access_ok,
  output logic                fetch_fail
);
  import itlb_pkg::*;

  localparam int IDX_BITS = $clog2(ENTRIES);
  localparam int TAG_LSB  = PAGE_BITS + IDX_BITS;
  localparam int TAG_BITS = EA_BITS - TAG_LSB;

  logic [IDX_BITS-1:0] f_idx;
  logic [IDX_BITS-1:0] m_idx;
  upd_op_e             upd_op;
  logic                rd_valid;
  logic [TAG_BITS-1:0] rd_tag;
  logic [PTE_BITS-1:0] rd_pte;
  logic                rd_hit;
  logic                pg_priv;

  itlb_hash #(.EA_BITS(EA_BITS), .PAGE_BITS(PAGE_BITS), .IDX_BITS(IDX_BITS))
    u_fhash (.ea(fetch_ea), .idx(f_idx));

  itlb_hash #(.EA_BITS(EA_BITS), .PAGE_BITS(PAGE_BITS), .IDX_BITS(IDX_BITS))
    u_mhash (.ea(mmu_ea), .idx(m_idx));

  // update decode: reset masks updates, invalidation outranks a load
  always_comb begin
    if (rst) begin
      upd_op = UPD_NONE;
    end else if (mmu_inval) begin
      upd_op = (|mmu_ea[KILL_ALL_MSB:KILL_ALL_LSB]) ? UPD_KILL_ALL : UPD_KILL_ONE;
    end else if (mmu_load) begin
      upd_op = UPD_LOAD;
    end else begin
      upd_op = UPD_NONE;
    end
  end

  itlb_entries #(
    .ENTRIES(ENTRIES), .IDX_BITS(IDX_BITS),
    .TAG_BITS(TAG_BITS), .PTE_BITS(PTE_BITS)
  ) u_entries (
    .clk    (clk),
    .rst    (rst),
    .op     (upd_op),
    .widx   (m_idx),
    .wtag   (mmu_ea[EA_BITS-1:TAG_LSB]),
    .wpte   (mmu_pte),
    .ridx   (f_idx),
    .rvalid (rd_valid),
    .rtag   (rd_tag),
    .rpte   (rd_pte)
  );

  assign rd_hit  = rd_valid && (rd_tag == fetch_ea[EA_BITS-1:TAG_LSB]);
  assign pg_priv = rd_pte[PTE_PRIV_BIT];

  itlb_prot #(
    .EA_BITS(EA_BITS), .RA_BITS(RA_BITS),
    .PAGE_BITS(PAGE_BITS), .PTE_BITS(PTE_BITS)
  ) u_prot (
    .xlate_en (xlate_en),
    .priv_en  (priv_en),
    .hit      (rd_hit),
    .ea       (fetch_ea),
    .pte      (rd_pte),
    .ra       (real_addr),
    .ok       (access_ok)
  );

  // sticky refusal record; clearing wins over setting
  always_ff @(posedge clk) begin
    if (rst || flush || mmu_load) begin
      fetch_fail <= 1'b0;
    end else if (fetch_req && !access_ok) begin
      fetch_fail <= 1'b1;
    end
  end

  logic unused_mmu_low;
  assign unused_mmu_low = ^mmu_ea[KILL_ALL_LSB-1:0];

endmodule

// File: rtl/itlb_xlate_chk.sv
`timescale 1ns/1ps
module itlb_xlate_chk #(
  parameter int RA_BITS   = 56,
  parameter int PAGE_BITS = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               fetch_req,
  input logic [RA_BITS-1:0] ea_low,
  input logic               xlate_en,
  input logic               priv_en,
  input logic               flush,
  input logic               mmu_load,
  input logic               pg_priv,
  input logic [RA_BITS-1:0] real_addr,
  input logic               access_ok,
  input logic               fetch_fail
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> !fetch_fail);

  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (xlate_en && access_ok) |-> real_addr[PAGE_BITS-1:0] == ea_low[PAGE_BITS-1:0]);

  assert_passthrough_R4: assert property (@(posedge clk) disable iff (rst)
    !xlate_en |-> (access_ok && real_addr == ea_low));

  assert_user_blocked_R5: assert property (@(posedge clk) disable iff (rst)
    (xlate_en && !priv_en && pg_priv) |-> !access_ok);

  assert_fail_sets_R10: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && !access_ok && !flush && !mmu_load) |=> fetch_fail);

  assert_fail_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (flush || mmu_load) |=> !fetch_fail);

  assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (fetch_fail && !flush && !mmu_load) |=> fetch_fail);

endmodule

bind itlb_xlate itlb_xlate_chk #(.RA_BITS(RA_BITS), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fetch_req  (fetch_req),
  .ea_low     (fetch_ea[RA_BITS-1:0]),
  .xlate_en   (xlate_en),
  .priv_en    (priv_en),
  .flush      (flush),
  .mmu_load   (mmu_load),
  .pg_priv    (pg_priv),
  .real_addr  (real_addr),
  .access_ok  (access_ok),
  .fetch_fail (fetch_fail)
);

// File: tb/tb_itlb_xlate.sv
`timescale 1ns/1ps
module tb_itlb_xlate;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_req = 1'b0;
  logic [63:0] fetch_ea = '0;
  logic        xlate_en = 1'b0;
  logic        priv_en = 1'b0;
  logic        flush = 1'b0;
  logic        mmu_load = 1'b0;
  logic        mmu_inval = 1'b0;
  logic [63:0] mmu_ea = '0;
  logic [63:0] mmu_pte = '0;
  logic [55:0] real_addr;
  logic        access_ok;
  logic        fetch_fail;

  itlb_xlate dut (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_ea(fetch_ea),
    .xlate_en(xlate_en), .priv_en(priv_en), .flush(flush),
    .mmu_load(mmu_load), .mmu_inval(mmu_inval), .mmu_ea(mmu_ea),
    .mmu_pte(mmu_pte), .real_addr(real_addr), .access_ok(access_ok),
    .fetch_fail(fetch_fail)
  );

  always #4 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;

  // behavioural reference state
  bit          m_vld [64];
  logic [45:0] m_tag [64];
  logic [63:0] m_pte [64];
  bit          m_ff;

  function automatic int hidx(input logic [63:0] a);
    return int'(a[17:12] ^ a[23:18] ^ a[29:24]);
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 64; i++) m_vld[i] = 1'b0;
    m_ff = 1'b0;
  endtask

  // one clock: drive after falling edge, compare, then advance the model
  task automatic step(input bit req, input logic [63:0] ea, input bit xl,
                      input bit pr, input bit fl, input bit ld, input bit iv,
                      input logic [63:0] mea, input logic [63:0] mpte,
                      input string rq);
    int  i;
    bit  hit;
    bit  eok;
    logic [55:0] era;
    fetch_req = req; fetch_ea = ea; xlate_en = xl; priv_en = pr;
    flush = fl; mmu_load = ld; mmu_inval = iv; mmu_ea = mea; mmu_pte = mpte;
    #1;
    i   = hidx(ea);
    hit = m_vld[i] && (m_tag[i] == ea[63:18]);
    if (xl) begin
      eok = hit && !(m_pte[i][3] && !pr);
      era = {m_pte[i][55:12], ea[11:0]};
    end else begin
      eok = 1'b1;
      era = ea[55:0];
    end
    chk(rq, "access_ok", 64'(access_ok), 64'(eok));
    if (eok) chk(rq, "real_addr", 64'(real_addr), 64'(era));
    chk(rq, "fetch_fail", 64'(fetch_fail), 64'(m_ff));
    @(posedge clk);
    if (fl || ld) m_ff = 1'b0;
    else if (req && !eok) m_ff = 1'b1;
    if (iv) begin
      if (mea[11:10] != 2'b00) begin
        for (int k = 0; k < 64; k++) m_vld[k] = 1'b0;
      end else begin
        m_vld[hidx(mea)] = 1'b0;
      end
    end else if (ld) begin
      m_vld[hidx(mea)] = 1'b1;
      m_tag[hidx(mea)] = mea[63:18];
      m_pte[hidx(mea)] = mpte;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fetch_req = 0; flush = 0; mmu_load = 0; mmu_inval = 0;
    @(posedge clk);
    @(posedge clk);
    model_clear();
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [63:0] ea_a, ea_b, ea_d, ea_e, ea_p, ea_q;
    logic [63:0] pte_a, pte_b, pte_d, pte_p, pte_q;
    logic [63:0] z;
    z     = '0;
    ea_a  = 64'h0000_1234_0567_8000;
    ea_b  = ea_a ^ 64'h41000;            // same folded index, other tag
    ea_d  = 64'h0000_0000_0500_0000;     // index 5 through the top field
    ea_e  = 64'h0000_0000_0218_3000;     // 3^6^2 = index 7
    ea_p  = 64'h0000_0000_4000_0000;     // index 0
    ea_q  = 64'h0000_0001_0000_9000;
    pte_a = 64'h00AB_CDEF_0123_4001;
    pte_b = 64'h0011_2233_4455_6101;
    pte_d = 64'h0000_0000_0099_9001;
    pte_p = 64'h0000_0000_0777_7008;     // privileged page
    pte_q = 64'h0000_0000_0444_4001;

    do_reset();
    // R1: empty table after reset, flag low
    step(1, ea_a, 1, 1, 0, 0, 0, z, z, "R1");
    step(0, ea_a, 1, 1, 0, 0, 0, z, z, "R1");
    do_reset();
    // R4: pass-through ignores the table and privilege
    step(1, 64'hFEDC_BA98_7654_3210, 0, 0, 0, 0, 0, z, z, "R4");
    step(1, 64'h0000_0000_0000_0ABC, 0, 1, 0, 0, 0, z, z, "R4");
    // R6: load then hit with offset carried
    step(0, z, 0, 1, 0, 1, 0, ea_a, pte_a, "R6");
    step(1, ea_a | 64'hABC, 1, 0, 0, 0, 0, z, z, "R3");
    // R2: collision with different tag misses, raises flag
    step(1, ea_b, 1, 1, 0, 0, 0, z, z, "R2");
    step(0, ea_a, 1, 1, 0, 0, 0, z, z, "R10");
    step(0, ea_a, 1, 1, 0, 1, 0, ea_b, pte_b, "R6");
    step(1, ea_b | 64'h10, 1, 0, 0, 0, 0, z, z, "R10");
    step(1, ea_a, 1, 1, 0, 0, 0, z, z, "R3");
    step(0, ea_a, 1, 1, 1, 0, 0, z, z, "R10");
    step(0, ea_a, 1, 1, 0, 0, 0, z, z, "R10");
    // R7: single invalidate aliasing onto a different tag
    step(0, z, 0, 1, 0, 1, 0, ea_d, pte_d, "R6");
    step(1, ea_d, 1, 1, 0, 0, 0, z, z, "R7");
    step(0, ea_d, 1, 1, 0, 0, 1, 64'h5000, z, "R7");
    step(1, ea_d, 1, 1, 0, 0, 0, z, z, "R7");
    // R2: folded index reached through all three fields
    step(0, z, 0, 1, 0, 1, 0, ea_e, pte_d, "R2");
    step(1, ea_e, 1, 1, 0, 0, 0, z, z, "R2");
    step(0, ea_e, 1, 1, 1, 0, 1, 64'h7000, z, "R2");
    step(1, ea_e, 1, 1, 0, 0, 0, z, z, "R2");
    // R5: privileged page
    step(0, z, 0, 1, 0, 1, 0, ea_p, pte_p, "R5");
    step(1, ea_p | 64'h44, 1, 1, 0, 0, 0, z, z, "R5");
    step(1, ea_p | 64'h44, 1, 0, 0, 0, 0, z, z, "R5");
    step(0, ea_p, 1, 1, 0, 0, 0, z, z, "R10");
    // R8: invalidate all
    step(0, z, 0, 1, 0, 1, 0, ea_a, pte_a, "R6");
    step(1, ea_a, 1, 1, 0, 0, 0, z, z, "R8");
    step(0, ea_a, 1, 1, 0, 0, 1, 64'h400, z, "R8");
    step(1, ea_a, 1, 1, 0, 0, 0, z, z, "R8");
    step(1, ea_p, 1, 1, 0, 0, 0, z, z, "R8");
    // R9: invalidate beats load in the same cycle
    step(0, z, 0, 1, 0, 1, 0, ea_q, pte_q, "R6");
    step(1, ea_q, 1, 1, 0, 0, 0, z, z, "R9");
    step(0, z, 0, 1, 0, 1, 1, ea_q, pte_a, "R9");
    step(1, ea_q, 1, 1, 0, 0, 0, z, z, "R9");
    // mixed traffic over a colliding address pool
    for (int n = 0; n < 3000; n++) begin
      int k;
      int j;
      logic [63:0] r_ea;
      logic [63:0] r_mea;
      logic [63:0] r_pte;
      bit r_ld;
      bit r_iv;
      k = $urandom_range(0, 7);
      j = $urandom_range(0, 7);
      r_ea  = 64'h7700_0000_0000_0000 | (64'(k & 3) << 12) | (64'(k >> 2) << 18)
              | 64'($urandom_range(0, 4095));
      r_mea = 64'h7700_0000_0000_0000 | (64'(j & 3) << 12) | (64'(j >> 2) << 18);
      if ($urandom_range(0, 15) == 0) r_mea[11:10] = 2'($urandom_range(1, 3));
      r_pte = {$urandom(), $urandom()};
      r_ld  = ($urandom_range(0, 4) == 0);
      r_iv  = ($urandom_range(0, 11) == 0);
      step($urandom_range(0, 9) < 7, r_ea, $urandom_range(0, 4) != 0,
           $urandom_range(0, 1) == 1, $urandom_range(0, 19) == 0,
           r_ld, r_iv, r_mea, r_pte, "R3");
    end
    // R1: reset in mid-run empties the table
    step(0, z, 0, 1, 0, 1, 0, ea_a, pte_a, "R6");
    do_reset();
    step(1, ea_a, 1, 1, 0, 0, 0, z, z, "R1");
    step(0, ea_a, 1, 1, 0, 0, 0, z, z, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule